// File: doc/BRIEF.md
# Single-Wire Bus Slave Slot Responder

This block is the device-side bit engine for an open-drain, single-wire bus that idles high through a pull-up. The master starts every bit slot by pulling the line low. The responder detects that falling edge and times the whole slot from it with a cycle counter. Whether a slot carries data from the master or asks the device for a bit is not visible on the wire. A `mode_read` input from the surrounding logic selects which kind of slot the next one is.

In a write slot the responder samples the synchronized line once, at a fixed point that sits in the middle of the legal sampling window. It then reports the bit with a one-cycle strobe. In a read slot it returns `tx_bit`. A zero is returned by pulling the line low from the moment the edge is detected until a fixed hold time has passed. A one is returned by leaving the line alone. When the hold time is over, the responder releases the line and pulses `tx_done`. After each slot, the block waits until it has seen the line high again before it accepts another edge.

Reset and presence handling, command decoding and byte assembly belong to other blocks.

Top module: `owsr_slot_responder`

## Requirements
- R1: While `rst_n` is low, and after it is released with no line activity, `line_drive_low`, `rx_valid` and `tx_done` are all 0.
- R2: In a write slot (`mode_read` = 0 at the edge), `rx_valid` is seen high after exactly SAMPLE_US*CLK_PER_US + SYNC_STAGES + 1 rising clock edges, counted from the line's fall. `rx_bit` is 1 if the line was high at the sample point and 0 if it was low.
- R3: A write slot yields exactly one `rx_valid` pulse, one clock wide. The slot produces no `tx_done` and never drives the line.
- R4: In a read slot (`mode_read` = 1) with `tx_bit` = 0, `line_drive_low` goes to 1 after SYNC_STAGES + 1 rising edges, counted from the fall. It stays at 1 for exactly HOLD_US*CLK_PER_US cycles and then returns to 0.
- R5: In a read slot with `tx_bit` = 1, `line_drive_low` stays 0 for the whole slot.
- R6: Every read slot gives exactly one `tx_done` pulse, one clock wide. The pulse is seen after SYNC_STAGES + 1 + HOLD_US*CLK_PER_US rising edges, counted from the fall, which is the same edge at which a held line is released. A read slot produces no `rx_valid`.
- R7: A write-0 in which the master holds the line low for the whole slot produces exactly one received bit.
- R8: A second falling edge inside an active slot, before its sample point, neither restarts the slot timing nor adds a received bit.
- R9: `mode_read` and `tx_bit` are captured when the slot starts. Changing them later in the slot has no effect on that slot.
- R10: After a slot ends, a line that is high for a single clock cycle is enough to re-arm the block. The next fall is then timed with the same latencies as in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level read back from the shared open-drain line |
| mode_read | input | 1 | 1: next slot returns data to the master; 0: next slot receives a bit |
| tx_bit | input | 1 | Bit to return in the next read slot |
| line_drive_low | output | 1 | 1 pulls the line low through the open-drain driver; 0 releases it |
| rx_valid | output | 1 | One-cycle strobe marking a received bit |
| rx_bit | output | 1 | Received bit, valid with `rx_valid` |
| tx_done | output | 1 | One-cycle strobe when a read slot has released the line |

## Verification
Two events can fall in the same clock cycle. In one, the block leaves its wait-for-high state. In the other, the next slot's falling edge is being detected. The bench provokes this by giving the line only one clock cycle of high level between slots, both after a held write-0 and after a driven read-0. It judges the following slot by its full latency and result checks. A slot that was lost, or that was timed from a late edge, shows up as a missing strobe or a shifted cycle count.

// File: rtl/owsr_pkg.sv
package owsr_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE      = 2'd0,
      SLOT_ACTIVE    = 2'd1,
      SLOT_WAIT_HIGH = 2'd2
   } slot_state_e;

   function automatic int unsigned pick_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/owsr_line_sync.sv
module owsr_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_level,
   output logic fall_seen
);

   logic [STAGES-1:0] chain;
   logic              prev_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain      <= '1;
         prev_level <= 1'b1;
      end else begin
         chain      <= {chain[STAGES-2:0], line_raw};
         prev_level <= chain[STAGES-1];
      end
   end

   assign line_level = chain[STAGES-1];
   assign fall_seen  = prev_level & ~line_level;

endmodule

// File: rtl/owsr_slot_timer.sv
module owsr_slot_timer
   import owsr_pkg::*;
#(
   parameter int unsigned SAMPLE_CYC = 1500,
   parameter int unsigned HOLD_CYC   = 2250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic at_sample,
   output logic at_release
);

   localparam int unsigned LAST  = pick_max(SAMPLE_CYC, HOLD_CYC);
   localparam int unsigned CNT_W = $clog2(LAST + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != CNT_W'(LAST)) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign at_sample  = run && (cnt == CNT_W'(SAMPLE_CYC - 1));
   assign at_release = run && (cnt == CNT_W'(HOLD_CYC - 1));

   // R4: a running count never passes its saturation limit
   assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cnt <= CNT_W'(LAST)));

endmodule

// File: rtl/owsr_slot_ctrl.sv
module owsr_slot_ctrl
   import owsr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fall_seen,
   input  logic line_level,
   input  logic mode_read,
   input  logic tx_bit,
   input  logic at_sample,
   input  logic at_release,
   output logic timer_run,
   output logic line_drive_low,
   output logic rx_valid,
   output logic rx_bit,
   output logic tx_done
);

   slot_state_e state;
   logic        lat_read;
   logic        lat_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= SLOT_IDLE;
         lat_read       <= 1'b0;
         lat_bit        <= 1'b1;
         line_drive_low <= 1'b0;
         rx_valid       <= 1'b0;
         rx_bit         <= 1'b0;
         tx_done        <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_done  <= 1'b0;
         unique case (state)
            SLOT_IDLE: begin
               if (fall_seen) begin
                  state          <= SLOT_ACTIVE;
                  lat_read       <= mode_read;
                  lat_bit        <= tx_bit;
                  line_drive_low <= mode_read & ~tx_bit;
               end
            end
            SLOT_ACTIVE: begin
               if (!lat_read && at_sample) begin
                  rx_valid <= 1'b1;
                  rx_bit   <= line_level;
                  state    <= SLOT_WAIT_HIGH;
               end else if (lat_read && at_release) begin
                  line_drive_low <= 1'b0;
                  tx_done        <= 1'b1;
                  state          <= SLOT_WAIT_HIGH;
               end
            end
            SLOT_WAIT_HIGH: begin
               if (line_level) state <= SLOT_IDLE;
            end
            default: state <= SLOT_IDLE;
         endcase
      end
   end

   assign timer_run = (state == SLOT_ACTIVE);

   assert_drive_read0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      line_drive_low |-> (lat_read && !lat_bit));

   assert_read1_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLOT_ACTIVE && lat_read && lat_bit) |-> !line_drive_low);

   assert_rx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_rx_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !lat_read);

   assert_txdone_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);

   assert_release_marks_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_drive_low) |-> tx_done);

   assert_wait_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLOT_WAIT_HIGH) |-> !line_drive_low);

endmodule

// File: rtl/owsr_slot_responder.sv
module owsr_slot_responder #(
   parameter int unsigned CLK_PER_US  = 50,
   parameter int unsigned SAMPLE_US   = 30,
   parameter int unsigned HOLD_US     = 45,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic mode_read,
   input  logic tx_bit,
   output logic line_drive_low,
   output logic rx_valid,
   output logic rx_bit,
   output logic tx_done
);

   localparam int unsigned SAMPLE_CYC = SAMPLE_US * CLK_PER_US;
   localparam int unsigned HOLD_CYC   = HOLD_US * CLK_PER_US;

   initial begin
      assert_sample_window_R2: assert (SAMPLE_US >= 15 && SAMPLE_US <= 60)
         else $error("sample point outside the receive window");
      assert_hold_window_R4: assert (HOLD_US > 15 && HOLD_US < 60)
         else $error("hold time must cover data-valid point and end inside the slot");
      assert_rate_R2: assert (CLK_PER_US >= 1)
         else $error("clock must provide at least one cycle per microsecond");
      assert_sync_depth_R10: assert (SYNC_STAGES >= 2)
         else $error("line synchronizer needs two or more stages");
   end

   logic line_level;
   logic fall_seen;
   logic timer_run;
   logic at_sample;
   logic at_release;

   owsr_line_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_raw  (line_in),
      .line_level(line_level),
      .fall_seen (fall_seen)
   );

   owsr_slot_timer #(
      .SAMPLE_CYC(SAMPLE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (timer_run),
      .at_sample (at_sample),
      .at_release(at_release)
   );

   owsr_slot_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .fall_seen     (fall_seen),
      .line_level    (line_level),
      .mode_read     (mode_read),
      .tx_bit        (tx_bit),
      .at_sample     (at_sample),
      .at_release    (at_release),
      .timer_run     (timer_run),
      .line_drive_low(line_drive_low),
      .rx_valid      (rx_valid),
      .rx_bit        (rx_bit),
      .tx_done       (tx_done)
   );

endmodule

// File: tb/owsr_slot_responder_bench.sv
module owsr_slot_responder_bench;

   localparam int U    = 10;
   localparam int SAMP = 30;
   localparam int HOLD = 45;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_low = 1'b0;
   logic mode_read = 1'b0;
   logic tx_bit = 1'b1;
   logic line_in;
   logic line_drive_low, rx_valid, rx_bit, tx_done;

   assign line_in = ~(master_low | line_drive_low);

   owsr_slot_responder #(
      .CLK_PER_US(U), .SAMPLE_US(SAMP), .HOLD_US(HOLD), .SYNC_STAGES(SYNC)
   ) u_owsr_slot_responder (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .mode_read(mode_read),
      .tx_bit(tx_bit), .line_drive_low(line_drive_low), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .tx_done(tx_done)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int rx_cnt = 0, rx_cyc = 0, rx_wide = 0;
   int td_cnt = 0, td_cyc = 0, td_wide = 0;
   int dr_cnt = 0, dr_rise = 0, dr_fall = 0;
   bit rx_val = 1'b0, rx_prev = 1'b0, td_prev = 1'b0, dr_prev = 1'b0;

   always @(negedge clk) begin
      if (rx_valid) begin rx_cnt++; rx_cyc = cyc; rx_val = rx_bit; end
      if (rx_valid && rx_prev) rx_wide++;
      if (tx_done) begin td_cnt++; td_cyc = cyc; end
      if (tx_done && td_prev) td_wide++;
      if (line_drive_low && !dr_prev) begin dr_cnt++; dr_rise = cyc; end
      if (!line_drive_low && dr_prev) dr_fall = cyc;
      rx_prev = rx_valid; td_prev = tx_done; dr_prev = line_drive_low;
   end

   int checks = 0, errors = 0;
   bit done = 1'b0;

   function automatic int exp_rx_lat();  return SAMP * U + SYNC + 1; endfunction
   function automatic int exp_drv_on();  return SYNC + 1; endfunction
   function automatic int exp_release(); return SYNC + 1 + HOLD * U; endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_slot(input bit rd, input bit txb, input bit wb, input int low_us,
                           input int total_us, input int rec_cyc, input bit glitch,
                           input bit flip, input string tag);
      int rx0, td0, dr0, t0, low_c;
      master_low = 1'b0;
      repeat (rec_cyc) @(negedge clk);
      mode_read = rd; tx_bit = txb;
      rx0 = rx_cnt; td0 = td_cnt; dr0 = dr_cnt;
      master_low = 1'b1; t0 = cyc;
      low_c = (!rd && !wb) ? total_us * U : low_us * U;
      for (int n = 1; n <= total_us * U; n++) begin
         @(negedge clk);
         if (n == low_c) master_low = 1'b0;
         if (glitch && n == (low_us + 2) * U) master_low = 1'b1;
         if (glitch && n == (low_us + 4) * U) master_low = 1'b0;
         if (flip && n == SYNC + 4) begin mode_read = ~rd; tx_bit = ~txb; end
      end
      if (!rd) begin
         chk(rx_cnt - rx0 == 1, {"R3 rx count", tag}, rx_cnt - rx0, 1);
         chk(rx_cyc - t0 == exp_rx_lat(), {"R2 rx latency", tag}, rx_cyc - t0, exp_rx_lat());
         chk(rx_val == wb, {"R2 rx bit", tag}, rx_val, wb);
         chk(td_cnt == td0, {"R3 no tx_done", tag}, td_cnt - td0, 0);
         chk(dr_cnt == dr0, {"R3 no drive", tag}, dr_cnt - dr0, 0);
      end else begin
         chk(td_cnt - td0 == 1, {"R6 tx_done count", tag}, td_cnt - td0, 1);
         chk(td_cyc - t0 == exp_release(), {"R6 tx_done latency", tag}, td_cyc - t0, exp_release());
         chk(rx_cnt == rx0, {"R6 no rx in read", tag}, rx_cnt - rx0, 0);
         if (!txb) begin
            chk(dr_cnt - dr0 == 1, {"R4 drive count", tag}, dr_cnt - dr0, 1);
            chk(dr_rise - t0 == exp_drv_on(), {"R4 drive start", tag}, dr_rise - t0, exp_drv_on());
            chk(dr_fall - t0 == exp_release(), {"R4 drive release", tag}, dr_fall - t0, exp_release());
         end else begin
            chk(dr_cnt == dr0, {"R5 read-1 no drive", tag}, dr_cnt - dr0, 0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5A17);
      repeat (4) @(negedge clk);
      chk(line_drive_low == 1'b0, "R1 drive in reset", line_drive_low, 0);
      chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
      chk(tx_done == 1'b0, "R1 tx_done in reset", tx_done, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(line_drive_low == 1'b0 && rx_cnt == 0 && td_cnt == 0, "R1 idle after reset",
          line_drive_low + rx_cnt + td_cnt, 0);

      run_slot(1'b0, 1'b1, 1'b1, 5, 70, 20, 1'b0, 1'b0, " R2 write-1");
      run_slot(1'b0, 1'b1, 1'b0, 0, 80, 20, 1'b0, 1'b0, " R7 held write-0");
      run_slot(1'b1, 1'b0, 1'b0, 2, 70, 20, 1'b0, 1'b0, " R4 read-0");
      run_slot(1'b1, 1'b1, 1'b0, 2, 65, 20, 1'b0, 1'b0, " R5 read-1");
      run_slot(1'b0, 1'b1, 1'b1, 3, 70, 20, 1'b1, 1'b0, " R8 second edge");
      run_slot(1'b1, 1'b0, 1'b0, 2, 70, 20, 1'b0, 1'b1, " R9 flip read");
      run_slot(1'b0, 1'b1, 1'b1, 4, 70, 20, 1'b0, 1'b1, " R9 flip write");
      run_slot(1'b0, 1'b1, 1'b0, 0, 65, 20, 1'b0, 1'b0, " R7 write-0");
      run_slot(1'b0, 1'b1, 1'b1, 4, 65, 1, 1'b0, 1'b0, " R10 one-cycle gap");
      run_slot(1'b1, 1'b0, 1'b0, 1, 60, 20, 1'b0, 1'b0, " R4 short slot");
      run_slot(1'b1, 1'b1, 1'b0, 1, 60, 1, 1'b0, 1'b0, " R10 gap after read");
      run_slot(1'b1, 1'b0, 1'b0, 1, 60, U, 1'b0, 1'b0, " R10 1us recovery");

      for (int i = 0; i < 40; i++) begin
         bit rd, txb, wb;
         int low_us, tot_us, rec;
         rd     = 1'($urandom_range(0, 1));
         txb    = 1'($urandom_range(0, 1));
         wb     = 1'($urandom_range(0, 1));
         low_us = rd ? $urandom_range(1, 5) : $urandom_range(1, 10);
         tot_us = $urandom_range(60, 120);
         rec    = (i % 7 == 3) ? 1 : $urandom_range(U, 5 * U);
         run_slot(rd, txb, wb, low_us, tot_us, rec, 1'b0, 1'b0, " random");
      end

      master_low = 1'b0;
      repeat (20) @(negedge clk);
      chk(rx_wide == 0, "R3 rx_valid one cycle", rx_wide, 0);
      chk(td_wide == 0, "R6 tx_done one cycle", td_wide, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule